// File: doc/BRIEF.md
# Sound Generator Command Register Decoder

This block sits between a host's 8-bit write port and the tone, noise and volume engines of a four-voice sound generator. The host puts a command byte on the data bus and pulses an active-low write strobe. The block captures the byte while the strobe is low. It commits the byte once, on the clock after the strobe returns high. It keeps eight registers: four 4-bit attenuations (0 is loudest, 15 is silent), three 10-bit tone periods and one 3-bit noise control.

Commands use a two-byte scheme. A byte with bit 7 set is a latch byte:
- Bits 6:5 name the channel.
- Bit 4 picks attenuation (1) or tone/noise (0).
- Bits 3:0 carry the low data.

The block remembers the latched register. A byte with bit 7 clear is a data byte, and it goes to that remembered register:
- For a tone, its six low bits become the upper six bits of the period.
- For an attenuation or the noise control, it replaces the low bits.

Every committed write to the noise control raises a one-cycle restart pulse for the noise engine.

Top module: `psg_cmd_decoder`

## Requirements
- R1: After synchronous reset every attenuation reads 4'hF, every tone period reads 0, the noise control reads 0, and the remembered register is tone channel 0, so a first data byte lands in period 0 bits 9:4.
- R2: A latch byte 1cc0ffff with cc in 0..2 writes ffff into bits 3:0 of tone period cc and leaves bits 9:4 and all other registers unchanged.
- R3: A data byte 0xffffff that follows a tone latch writes its bits 5:0 into bits 9:4 of that tone period and keeps bits 3:0.
- R4: A latch byte 1cc1aaaa writes aaaa into attenuation cc (cc in 0..3) and leaves the other channels unchanged.
- R5: A latch byte 11100bff writes the noise control: output noise_white_o takes b (1 white, 0 periodic) and noise_rate_o takes ff.
- R6: noise_restart_o is high for exactly one cycle after each committed noise-control write, in the same cycle the new noise value appears. It stays low for every other write.
- R7: Each low pulse of wr_n commits exactly one byte: the last value seen on din while wr_n was low. No register changes while wr_n stays low or stays high.
- R8: A data byte that follows an attenuation latch replaces that attenuation with its bits 3:0. A data byte that follows the noise latch replaces the noise control with its bits 2:0 and raises the restart pulse.
- R9: The remembered register persists across data bytes, so consecutive data bytes all go to the same register until the next latch byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single-phase clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Active-low write strobe |
| din | input | 8 | Command byte |
| atten_o | output | 16 | Attenuations, channel c at bits 4c+3:4c |
| period_o | output | 30 | Tone periods, channel c at bits 10c+9:10c |
| noise_white_o | output | 1 | Noise type, 1 = white |
| noise_rate_o | output | 2 | Noise shift-rate select |
| noise_restart_o | output | 1 | One-cycle noise restart pulse |

## Verification
Directed byte sequences are used, and each one separates a different decoding path:
- Latch bytes on every channel and type show whether the channel and type fields are decoded in the right places.
- A tone latch followed by a data byte shows whether the two halves of a period are merged or overwrite each other.
- Data bytes after attenuation and noise latches, and repeated data bytes, show whether the remembered register is kept.
- A held strobe with a changing bus, and idle cycles with the strobe high, show whether exactly one byte is committed per pulse.
- The restart pulse is sampled after every write, so it can be seen that only noise writes produce it.

// File: rtl/psg_cmd_pkg.sv
package psg_cmd_pkg;
    localparam int NUM_TONE = 3;
    localparam int NUM_CHAN = NUM_TONE + 1;
    localparam int PERIOD_W = 10;
    localparam int ATT_W    = 4;
    localparam int NOISE_W  = 3;
    localparam int LO_W     = 4;
    localparam int HI_W     = PERIOD_W - LO_W;
    localparam int CH_W     = $clog2(NUM_CHAN);
    localparam logic [ATT_W-1:0] ATT_SILENT = '1;

    typedef struct packed {
        logic [CH_W-1:0] chan;
        logic            is_att;
    } reg_sel_t;

    typedef struct packed {
        logic [NUM_TONE-1:0] tone_lo_we;
        logic [NUM_TONE-1:0] tone_hi_we;
        logic [NUM_CHAN-1:0] att_we;
        logic                noise_we;
        logic                sel_we;
        reg_sel_t            sel_next;
        logic [HI_W-1:0]     payload;
    } reg_op_t;

    function automatic logic is_latch_byte(input logic [7:0] b);
        return b[7];
    endfunction

    function automatic reg_sel_t latch_target(input logic [7:0] b);
        reg_sel_t s;
        s.chan   = b[6:5];
        s.is_att = b[4];
        return s;
    endfunction
endpackage

// File: rtl/psg_wr_sync.sv
module psg_wr_sync
    import psg_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_n,
    input  logic [7:0] din,
    output logic       commit,
    output logic [7:0] byte_q
);
    logic wr_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_n_q <= 1'b1;
            byte_q <= '0;
        end else begin
            wr_n_q <= wr_n;
            if (!wr_n) byte_q <= din;
        end
    end

    assign commit = wr_n && !wr_n_q;
endmodule

// File: rtl/psg_cmd_decode.sv
module psg_cmd_decode
    import psg_cmd_pkg::*;
(
    input  logic     commit,
    input  logic [7:0] byte_q,
    input  reg_sel_t sel_q,
    output reg_op_t  op
);
    reg_sel_t target;
    logic     latch;

    always_comb begin
        op     = '0;
        latch  = is_latch_byte(byte_q);
        target = latch ? latch_target(byte_q) : sel_q;
        op.payload  = latch ? {{(HI_W-LO_W){1'b0}}, byte_q[LO_W-1:0]} : byte_q[HI_W-1:0];
        op.sel_next = target;
        if (commit) begin
            op.sel_we = latch;
            if (target.is_att) begin
                for (int c = 0; c < NUM_CHAN; c++)
                    if (target.chan == c[CH_W-1:0]) op.att_we[c] = 1'b1;
            end else if (target.chan == CH_W'(NUM_CHAN-1)) begin
                op.noise_we = 1'b1;
            end else begin
                for (int c = 0; c < NUM_TONE; c++)
                    if (target.chan == c[CH_W-1:0]) begin
                        op.tone_lo_we[c] = latch;
                        op.tone_hi_we[c] = !latch;
                    end
            end
        end
    end
endmodule

// File: rtl/psg_reg_bank.sv
module psg_reg_bank
    import psg_cmd_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  reg_op_t                      op,
    output logic [NUM_CHAN*ATT_W-1:0]    atten,
    output logic [NUM_TONE*PERIOD_W-1:0] period,
    output logic [NOISE_W-1:0]           noise
);
    for (genvar c = 0; c < NUM_TONE; c++) begin : g_tone
        logic [PERIOD_W-1:0] per_q;
        always_ff @(posedge clk) begin
            if (rst) per_q <= '0;
            else begin
                if (op.tone_lo_we[c]) per_q[LO_W-1:0]        <= op.payload[LO_W-1:0];
                if (op.tone_hi_we[c]) per_q[PERIOD_W-1:LO_W] <= op.payload;
            end
        end
        assign period[c*PERIOD_W +: PERIOD_W] = per_q;
    end

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_att
        logic [ATT_W-1:0] att_q;
        always_ff @(posedge clk) begin
            if (rst)              att_q <= ATT_SILENT;
            else if (op.att_we[c]) att_q <= op.payload[ATT_W-1:0];
        end
        assign atten[c*ATT_W +: ATT_W] = att_q;
    end

    always_ff @(posedge clk) begin
        if (rst)              noise <= '0;
        else if (op.noise_we) noise <= op.payload[NOISE_W-1:0];
    end
endmodule

// File: rtl/psg_cmd_decoder.sv
module psg_cmd_decoder
    import psg_cmd_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_n,
    input  logic [7:0]                   din,
    output logic [NUM_CHAN*ATT_W-1:0]    atten_o,
    output logic [NUM_TONE*PERIOD_W-1:0] period_o,
    output logic                         noise_white_o,
    output logic [1:0]                   noise_rate_o,
    output logic                         noise_restart_o
);
    logic              commit;
    logic [7:0]        byte_q;
    reg_sel_t          sel_q;
    reg_op_t           op;
    logic [NOISE_W-1:0] noise;

    psg_wr_sync u_sync (
        .clk(clk), .rst(rst), .wr_n(wr_n), .din(din),
        .commit(commit), .byte_q(byte_q)
    );

    psg_cmd_decode u_dec (
        .commit(commit), .byte_q(byte_q), .sel_q(sel_q), .op(op)
    );

    psg_reg_bank u_bank (
        .clk(clk), .rst(rst), .op(op),
        .atten(atten_o), .period(period_o), .noise(noise)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q           <= '0;
            noise_restart_o <= 1'b0;
        end else begin
            if (op.sel_we) sel_q <= op.sel_next;
            noise_restart_o <= op.noise_we;
        end
    end

    assign noise_white_o = noise[2];
    assign noise_rate_o  = noise[1:0];
endmodule

// File: rtl/psg_cmd_checker.sv
module psg_cmd_checker
    import psg_cmd_pkg::*;
(
    input logic                         clk,
    input logic                         rst,
    input logic                         wr_n,
    input logic [NUM_CHAN*ATT_W-1:0]    atten_o,
    input logic [NUM_TONE*PERIOD_W-1:0] period_o,
    input logic                         noise_white_o,
    input logic [1:0]                   noise_rate_o,
    input logic                         noise_restart_o
);
    AST_HOLD_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
        !wr_n |=> ($stable(atten_o) && $stable(period_o) && $stable(noise_rate_o) && $stable(noise_white_o))); // R7

    AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (wr_n && $past(wr_n)) |=> ($stable(atten_o) && $stable(period_o) && $stable(noise_white_o))); // R7

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        noise_restart_o |=> !noise_restart_o); // R6

    AST_PULSE_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
        noise_restart_o |-> ($past(wr_n) && !$past(wr_n, 2))); // R6
endmodule

bind psg_cmd_decoder psg_cmd_checker u_chk (
    .clk(clk), .rst(rst), .wr_n(wr_n), .atten_o(atten_o), .period_o(period_o),
    .noise_white_o(noise_white_o), .noise_rate_o(noise_rate_o),
    .noise_restart_o(noise_restart_o)
);

// File: tb/sim_psg_cmd_decoder.sv
module sim_psg_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_n = 1'b1;
    logic [7:0]  din = 8'h00;
    logic [15:0] atten_o;
    logic [29:0] period_o;
    logic        noise_white_o;
    logic [1:0]  noise_rate_o;
    logic        noise_restart_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [3:0] e_att [4];
    logic [9:0] e_per [3];
    logic [2:0] e_noise;
    logic       pulse_seen;

    always #5 clk = ~clk;

    psg_cmd_decoder u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int c = 0; c < 4; c++) check(req, 32'(atten_o[c*4 +: 4]), 32'(e_att[c]));
        for (int c = 0; c < 3; c++) check(req, 32'(period_o[c*10 +: 10]), 32'(e_per[c]));
        check(req, 32'({noise_white_o, noise_rate_o}), 32'(e_noise));
    endtask

    // one strobe: byte held low for one clock, released, then sampled after the commit edge
    task automatic wr(input logic [7:0] b);
        @(negedge clk); din = b; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); pulse_seen = noise_restart_o;
    endtask

    task automatic t_reset;
        for (int c = 0; c < 4; c++) e_att[c] = 4'hF;
        for (int c = 0; c < 3; c++) e_per[c] = '0;
        e_noise = '0;
        check_all("R1 reset");
        check("R1 no pulse", 32'(noise_restart_o), 0);
        wr(8'h2A);                       // data byte to default tone 0
        e_per[0][9:4] = 6'h2A;
        check_all("R1 default pointer");
        check("R6 no pulse tone", 32'(pulse_seen), 0);
    endtask

    task automatic t_tone;
        wr(8'hA5); e_per[1][3:0] = 4'h5;         // R2 tone 1 low nibble
        check_all("R2 tone1 latch");
        wr(8'h3F); e_per[1][9:4] = 6'h3F;        // R3
        check_all("R3 tone1 data");
        wr(8'h8C); e_per[0][3:0] = 4'hC;         // R2 keeps upper
        check_all("R2 tone0 keeps high");
        wr(8'h11); e_per[0][9:4] = 6'h11;
        check_all("R3 tone0 = 11C");
        wr(8'hC7); e_per[2][3:0] = 4'h7;
        wr(8'h15); e_per[2][9:4] = 6'h15;        // R9 repeat data
        wr(8'h2B); e_per[2][9:4] = 6'h2B;
        check_all("R9 repeated data bytes");
        check("R6 no pulse tone", 32'(pulse_seen), 0);
    endtask

    task automatic t_atten;
        for (int c = 0; c < 4; c++) begin
            wr(8'h90 | 8'(c << 5) | 8'(c + 3)); e_att[c] = 4'(c + 3);
            check("R6 no pulse atten", 32'(pulse_seen), 0);
        end
        check_all("R4 atten per channel");
        wr(8'hB0); e_att[1] = 4'h0;
        wr(8'h09); e_att[1] = 4'h9;              // R8 data after atten latch
        check_all("R8 data after atten");
    endtask

    task automatic t_noise;
        wr(8'hE4); e_noise = 3'b100;
        check_all("R5 white rate 0");
        check("R6 pulse on noise latch", 32'(pulse_seen), 1);
        @(negedge clk);
        check("R6 pulse one cycle", 32'(noise_restart_o), 0);
        wr(8'hE3); e_noise = 3'b011;
        check_all("R5 periodic rate 3");
        wr(8'h06); e_noise = 3'b110;             // R8 data after noise latch
        check_all("R8 data after noise");
        check("R8 pulse on noise data", 32'(pulse_seen), 1);
        wr(8'hF8); e_att[3] = 4'h8;
        check("R6 no pulse atten3", 32'(pulse_seen), 0);
        check_all("R4 noise atten");
    endtask

    task automatic t_strobe;
        @(negedge clk); din = 8'h81; wr_n = 1'b0;
        @(negedge clk); din = 8'h8E;
        @(negedge clk);
        check_all("R7 no change while low");
        wr_n = 1'b1;
        @(negedge clk);
        e_per[0][3:0] = 4'hE;
        check_all("R7 last byte committed");
        repeat (4) @(negedge clk);
        din = 8'h9F;
        @(negedge clk);
        check_all("R7 no change while high");
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_tone();
        t_atten();
        t_noise();
        t_strobe();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule